// File: doc/BRIEF.md
# Multi-Mode Serial Receiver

This block turns a serial bit stream into bytes and keeps the receive status that a processor polls or takes interrupts on. It has three frame formats, chosen by `mode_i`. In the plain asynchronous format a frame is a start bit, eight data bits and a stop bit, with an optional parity bit before the stop bit. In the multiprocessor asynchronous format an address/data select bit always comes after the eighth data bit and parity is never checked. In the clocked synchronous format, eight bits are shifted in on the rising edges of an external shift clock and there is no start or stop bit.

The asynchronous formats need a sample strobe from an outside baud generator, `OVS` strobes per bit period. The receiver confirms a start bit at its midpoint and then samples every later bit at its centre. A completed frame is written to a byte register and sets a full flag. The full flag and the parity, overrun and framing error flags are sticky. A read pulse clears the full flag and a separate clear pulse clears the three error flags. When interrupts are enabled, any set flag raises an interrupt request.

Top module: `ser_rx_multi`

## Requirements
- R1: After a synchronous reset, `rx_data_o` is 0 and `ad_o`, `full_o`, `perr_o`, `oerr_o`, `ferr_o` and `irq_o` are all 0.
- R2: `mode_i` values 0 and 3 select plain asynchronous frames, 1 selects multiprocessor frames and 2 selects synchronous frames. In asynchronous frames a low line at a sample strobe starts a frame. Each bit lasts `OVS` strobes and the data bits arrive least significant first. The byte is stored and `full_o` is set once the stop bit has been sampled.
- R3: In plain asynchronous mode with `par_en_i`=1, a parity bit follows bit 7. With `par_odd_i`=1 the data bits and the parity bit must hold an odd number of ones, and with `par_odd_i`=0 an even number. On a mismatch `perr_o` is set in the same cycle as `full_o`, and the byte is still stored.
- R4: In multiprocessor mode a select bit follows bit 7 and is presented on `ad_o` together with the stored byte. Parity is never checked in this mode, whatever `par_en_i` holds. `ad_o` is 0 after a frame in any other mode.
- R5: In synchronous mode the byte is built from `rxd_i` sampled on eight rising edges of `sck_i`, least significant bit first. `full_o` is set with the eighth bit. `perr_o` and `ferr_o` never become 1 in this mode.
- R6: In an asynchronous mode a stop bit sampled as 0 sets `ferr_o` in the same cycle as `full_o`, and the byte is still stored.
- R7: If a frame completes while `full_o` is 1 and no read is made in that cycle, `oerr_o` is set and `rx_data_o`, `ad_o` and `full_o` keep their values.
- R8: A start bit that is high again when it is re-sampled at its midpoint returns the receiver to idle without setting any flag. The next frame is still received correctly.
- R9: A pulse on `rd_i` clears `full_o` and leaves `rx_data_o` unchanged. A pulse on `clr_err_i` clears `perr_o`, `oerr_o` and `ferr_o` and leaves `full_o` unchanged.
- R10: `irq_o` is 1 exactly when `rie_i` is 1 and at least one of `full_o`, `perr_o`, `oerr_o` and `ferr_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Frame format select |
| par_en_i | input | 1 | Parity bit present (plain asynchronous mode only) |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| samp_stb_i | input | 1 | Sample strobe, `OVS` per bit period |
| rxd_i | input | 1 | Serial data line, idles high |
| sck_i | input | 1 | External shift clock for synchronous mode |
| rd_i | input | 1 | Read pulse, clears the full flag |
| clr_err_i | input | 1 | Clears the three error flags |
| rie_i | input | 1 | Receive interrupt enable |
| rx_data_o | output | 8 | Last stored byte |
| ad_o | output | 1 | Address/data select bit of the stored frame |
| full_o | output | 1 | Receive data full flag |
| perr_o | output | 1 | Parity error flag |
| oerr_o | output | 1 | Overrun error flag |
| ferr_o | output | 1 | Framing error flag |
| irq_o | output | 1 | Receive interrupt request |

## Verification
The bench sends frames with matching and mismatching parity under both parity senses, and a select bit that would fail a parity check if one were made. A design that checks parity in the wrong mode, or takes the wrong sense, reports a false `perr_o` or misses a real one. It sends a low stop bit in each asynchronous mode and in synchronous mode. Leaking the framing check into synchronous mode shows up as a stray `ferr_o`, and dropping the byte on an error shows up as stale data. A second frame is sent without a read, in both an asynchronous and the synchronous format, to catch a design that overwrites the held byte. A start glitch shorter than half a bit catches a receiver that never re-checks its start bit and goes on to build a corrupted byte.

// File: rtl/ser_rx_pkg.sv
package ser_rx_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        MODE_ASYNC     = 2'd0,
        MODE_MPROC     = 2'd1,
        MODE_SYNC      = 2'd2,
        MODE_ASYNC_ALT = 2'd3
    } rx_mode_e;

    typedef enum logic [2:0] {
        AS_IDLE  = 3'd0,
        AS_START = 3'd1,
        AS_DATA  = 3'd2,
        AS_EXTRA = 3'd3,
        AS_STOP  = 3'd4
    } as_state_e;

    typedef struct packed {
        logic              done;
        logic [DATA_W-1:0] data;
        logic              ad;
        logic              perr;
        logic              ferr;
    } rx_frame_t;

    // 1 when the data bits plus the parity bit break the selected sense
    function automatic logic parity_bad(input logic [DATA_W-1:0] d,
                                        input logic pbit,
                                        input logic odd);
        logic ones_odd;
        ones_odd = (^d) ^ pbit;
        return odd ? ~ones_odd : ones_odd;
    endfunction

    function automatic logic mode_is_async(input rx_mode_e m);
        return m != MODE_SYNC;
    endfunction

endpackage

// File: rtl/ser_rx_sync.sv
module ser_rx_sync #(
    parameter int          W       = 2,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= RST_VAL;
                    else     chain[s] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= RST_VAL;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/ser_rx_async.sv
module ser_rx_async
    import ser_rx_pkg::*;
#(
    parameter int OVS = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  rx_mode_e  mode,
    input  logic      par_en,
    input  logic      par_odd,
    input  logic      samp_stb,
    input  logic      rxd,
    output rx_frame_t frm
);
    localparam int CNT_W = (OVS > 2) ? $clog2(OVS) : 1;
    localparam int HALF  = OVS / 2;
    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
    localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(HALF - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

    as_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [BIT_W-1:0]  bitn;
    logic [DATA_W-1:0] shreg;
    logic              xbit;
    logic              has_extra;
    logic              chk_par;
    logic              bit_point;

    assign has_extra = (mode == MODE_MPROC) || par_en;
    assign chk_par   = (mode != MODE_MPROC) && par_en;
    assign bit_point = samp_stb && (cnt == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state <= AS_IDLE;
            cnt   <= '0;
            bitn  <= '0;
            shreg <= '0;
            xbit  <= 1'b0;
            frm   <= '0;
        end else begin
            frm.done <= 1'b0;
            if (samp_stb) begin
                case (state)
                    AS_IDLE: begin
                        if (!rxd) begin
                            state <= AS_START;
                            cnt   <= '0;
                        end
                    end
                    AS_START: begin
                        if (cnt == CNT_MID) begin
                            cnt  <= '0;
                            bitn <= '0;
                            state <= rxd ? AS_IDLE : AS_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: begin
                        if (bit_point) begin
                            cnt <= '0;
                            case (state)
                                AS_DATA: begin
                                    shreg <= {rxd, shreg[DATA_W-1:1]};
                                    if (bitn == BIT_LAST)
                                        state <= has_extra ? AS_EXTRA : AS_STOP;
                                    else
                                        bitn <= bitn + 1'b1;
                                end
                                AS_EXTRA: begin
                                    xbit  <= rxd;
                                    state <= AS_STOP;
                                end
                                default: begin
                                    frm.done <= 1'b1;
                                    frm.data <= shreg;
                                    frm.ad   <= (mode == MODE_MPROC) && xbit;
                                    frm.perr <= chk_par && parity_bad(shreg, xbit, par_odd);
                                    frm.ferr <= ~rxd;
                                    state    <= AS_IDLE;
                                end
                            endcase
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    // R2: a frame is only ever delivered out of the stop-bit state
    p_frame_from_stop_r2: assert property (@(posedge clk) disable iff (rst)
        frm.done |-> $past(state) == AS_STOP);

    // R8: a line that is high again at the start midpoint never reaches the data bits
    p_false_start_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (en && samp_stb && state == AS_START && cnt == CNT_MID && rxd)
        |=> (state == AS_IDLE && !frm.done));
endmodule

// File: rtl/ser_rx_shift.sv
module ser_rx_shift
    import ser_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      sck,
    input  logic      rxd,
    output rx_frame_t frm
);
    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

    logic              sck_d;
    logic              rise;
    logic [BIT_W-1:0]  cnt;
    logic [DATA_W-1:0] shreg;

    assign rise = sck && !sck_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d <= 1'b1;
            cnt   <= '0;
            shreg <= '0;
            frm   <= '0;
        end else begin
            sck_d    <= sck;
            frm.done <= 1'b0;
            if (!en) begin
                cnt <= '0;
            end else if (rise) begin
                shreg <= {rxd, shreg[DATA_W-1:1]};
                if (cnt == BIT_LAST) begin
                    cnt      <= '0;
                    frm.done <= 1'b1;
                    frm.data <= {rxd, shreg[DATA_W-1:1]};
                    frm.ad   <= 1'b0;
                    frm.perr <= 1'b0;
                    frm.ferr <= 1'b0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R5: a synchronous byte completes only on a shift-clock rising edge
    p_sync_on_edge_r5: assert property (@(posedge clk) disable iff (rst)
        frm.done |-> ($past(sck) && !$past(sck_d)));
endmodule

// File: rtl/ser_rx_status.sv
module ser_rx_status
    import ser_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  rx_frame_t         frm,
    input  logic              rd,
    input  logic              clr_err,
    input  logic              rie,
    output logic [DATA_W-1:0] data,
    output logic              ad,
    output logic              full,
    output logic              perr,
    output logic              oerr,
    output logic              ferr,
    output logic              irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data <= '0;
            ad   <= 1'b0;
            full <= 1'b0;
            perr <= 1'b0;
            oerr <= 1'b0;
            ferr <= 1'b0;
        end else begin
            if (clr_err) begin
                perr <= 1'b0;
                oerr <= 1'b0;
                ferr <= 1'b0;
            end
            if (rd) full <= 1'b0;
            if (frm.done) begin
                if (full && !rd) begin
                    oerr <= 1'b1;
                end else begin
                    data <= frm.data;
                    ad   <= frm.ad;
                    full <= 1'b1;
                    if (frm.perr) perr <= 1'b1;
                    if (frm.ferr) ferr <= 1'b1;
                end
            end
        end
    end

    assign irq = rie && (full || perr || oerr || ferr);

    // R7: an unread byte survives a second frame, which raises overrun
    p_ovr_keeps_data_r7: assert property (@(posedge clk) disable iff (rst)
        (frm.done && full && !rd) |=> (oerr && full && data == $past(data) && ad == $past(ad)));

    // R9: a read without a new frame empties the register and keeps the byte
    p_read_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (rd && !frm.done) |=> (!full && data == $past(data)));

    // R9: error clear without a new frame drops all three error flags
    p_clr_err_r9: assert property (@(posedge clk) disable iff (rst)
        (clr_err && !frm.done) |=> (!perr && !oerr && !ferr));

    // R10: the request is gated by the enable
    p_irq_gate_r10: assert property (@(posedge clk) disable iff (rst)
        !rie |-> !irq);

    // R10: a full register always requests when enabled
    p_irq_full_r10: assert property (@(posedge clk) disable iff (rst)
        (rie && full) |-> irq);
endmodule

// File: rtl/ser_rx_multi.sv
module ser_rx_multi
    import ser_rx_pkg::*;
#(
    parameter int OVS         = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_i,
    input  logic              par_en_i,
    input  logic              par_odd_i,
    input  logic              samp_stb_i,
    input  logic              rxd_i,
    input  logic              sck_i,
    input  logic              rd_i,
    input  logic              clr_err_i,
    input  logic              rie_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              ad_o,
    output logic              full_o,
    output logic              perr_o,
    output logic              oerr_o,
    output logic              ferr_o,
    output logic              irq_o
);
    rx_mode_e  mode;
    logic [1:0] pins_s;
    logic      rxd_s;
    logic      sck_s;
    logic      async_en;
    rx_frame_t async_frm;
    rx_frame_t sync_frm;
    rx_frame_t frm;

    assign mode     = rx_mode_e'(mode_i);
    assign async_en = mode_is_async(mode);

    ser_rx_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({sck_i, rxd_i}),
        .q_o (pins_s)
    );
    assign sck_s = pins_s[1];
    assign rxd_s = pins_s[0];

    ser_rx_async #(.OVS(OVS)) u_async (
        .clk      (clk),
        .rst      (rst),
        .en       (async_en),
        .mode     (mode),
        .par_en   (par_en_i),
        .par_odd  (par_odd_i),
        .samp_stb (samp_stb_i),
        .rxd      (rxd_s),
        .frm      (async_frm)
    );

    ser_rx_shift u_shift (
        .clk (clk),
        .rst (rst),
        .en  (!async_en),
        .sck (sck_s),
        .rxd (rxd_s),
        .frm (sync_frm)
    );

    assign frm = async_en ? async_frm : sync_frm;

    ser_rx_status u_status (
        .clk     (clk),
        .rst     (rst),
        .frm     (frm),
        .rd      (rd_i),
        .clr_err (clr_err_i),
        .rie     (rie_i),
        .data    (rx_data_o),
        .ad      (ad_o),
        .full    (full_o),
        .perr    (perr_o),
        .oerr    (oerr_o),
        .ferr    (ferr_o),
        .irq     (irq_o)
    );

    // R2: the full flag rises only on a delivered frame
    p_full_from_frame_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(full_o) |-> $past(frm.done));

    // R3: parity errors come only from the plain asynchronous format
    p_perr_mode_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(perr_o) |-> ($past(mode_i) != MODE_MPROC && $past(mode_i) != MODE_SYNC));

    // R5: the synchronous format never raises a framing error
    p_sync_no_ferr_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(ferr_o) |-> $past(mode_i) != MODE_SYNC);

    // R6: a framing error always comes with a full register
    p_ferr_with_full_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(ferr_o) |-> full_o);
endmodule

// File: tb/ser_rx_multi_bench.sv
module ser_rx_multi_bench;
    localparam int OVS = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode_i = 2'd0;
    logic       par_en_i = 1'b0;
    logic       par_odd_i = 1'b0;
    logic       samp_stb_i = 1'b1;
    logic       rxd_i = 1'b1;
    logic       sck_i = 1'b1;
    logic       rd_i = 1'b0;
    logic       clr_err_i = 1'b0;
    logic       rie_i = 1'b1;
    logic [7:0] rx_data_o;
    logic       ad_o, full_o, perr_o, oerr_o, ferr_o, irq_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ser_rx_multi #(.OVS(OVS), .SYNC_STAGES(2)) u_ser_rx_multi (
        .clk (clk), .rst (rst), .mode_i (mode_i), .par_en_i (par_en_i),
        .par_odd_i (par_odd_i), .samp_stb_i (samp_stb_i), .rxd_i (rxd_i),
        .sck_i (sck_i), .rd_i (rd_i), .clr_err_i (clr_err_i), .rie_i (rie_i),
        .rx_data_o (rx_data_o), .ad_o (ad_o), .full_o (full_o), .perr_o (perr_o),
        .oerr_o (oerr_o), .ferr_o (ferr_o), .irq_o (irq_o)
    );

    // {mode[15:14], par_en[13], par_odd[12], data[11:4], extra[3], stop[2], exp_perr[1], exp_ferr[0]}
    localparam logic [15:0] VEC [11] = '{
        {2'd0, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b1, 1'b0, 1'b0},
        {2'd0, 1'b1, 1'b0, 8'h3C, 1'b0, 1'b1, 1'b0, 1'b0},
        {2'd0, 1'b1, 1'b0, 8'h3C, 1'b1, 1'b1, 1'b1, 1'b0},
        {2'd0, 1'b1, 1'b1, 8'h01, 1'b0, 1'b1, 1'b0, 1'b0},
        {2'd0, 1'b1, 1'b1, 8'h01, 1'b1, 1'b1, 1'b1, 1'b0},
        {2'd0, 1'b0, 1'b0, 8'h81, 1'b0, 1'b0, 1'b0, 1'b1},
        {2'd1, 1'b1, 1'b0, 8'h55, 1'b1, 1'b1, 1'b0, 1'b0},
        {2'd1, 1'b0, 1'b0, 8'hF0, 1'b0, 1'b0, 1'b0, 1'b1},
        {2'd2, 1'b0, 1'b0, 8'h96, 1'b0, 1'b0, 1'b0, 1'b0},
        {2'd2, 1'b1, 1'b0, 8'h7E, 1'b1, 1'b0, 1'b0, 1'b0},
        {2'd3, 1'b1, 1'b0, 8'h07, 1'b0, 1'b1, 1'b1, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        rxd_i = b;
        repeat (OVS) @(negedge clk);
    endtask

    task automatic send_async(input logic [7:0] d, input logic has_x,
                              input logic x, input logic stop);
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(d[i]);
        if (has_x) send_bit(x);
        send_bit(stop);
        rxd_i = 1'b1;
        repeat (OVS) @(negedge clk);
    endtask

    task automatic send_sync(input logic [7:0] d);
        for (int i = 0; i < 8; i++) begin
            sck_i = 1'b0;
            rxd_i = d[i];
            repeat (3) @(negedge clk);
            sck_i = 1'b1;
            repeat (3) @(negedge clk);
        end
        rxd_i = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic pulse_rd();
        rd_i = 1'b1;
        @(negedge clk);
        rd_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_clr();
        clr_err_i = 1'b1;
        @(negedge clk);
        clr_err_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_mode(input logic [1:0] m, input logic pen, input logic podd);
        mode_i    = m;
        par_en_i  = pen;
        par_odd_i = podd;
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired before the run ended");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 data after reset", 32'(rx_data_o), 32'h0);
        check("R1 flags after reset",
              {26'd0, ad_o, full_o, perr_o, oerr_o, ferr_o, irq_o}, 32'h0);

        // table of frames: R2 R3 R4 R5 R6
        for (int v = 0; v < 11; v++) begin
            logic [1:0] m;
            logic       pen, podd, x, stp, ep, ef, hx, eadx;
            logic [7:0] d;
            m = VEC[v][15:14]; pen = VEC[v][13]; podd = VEC[v][12];
            d = VEC[v][11:4];  x = VEC[v][3]; stp = VEC[v][2];
            ep = VEC[v][1];    ef = VEC[v][0];
            hx   = (m == 2'd1) || (pen && m != 2'd2);
            eadx = (m == 2'd1) ? x : 1'b0;
            set_mode(m, pen, podd);
            if (m == 2'd2) send_sync(d);
            else           send_async(d, hx, x, stp);
            check($sformatf("R2/R5 data vec %0d", v), 32'(rx_data_o), 32'(d));
            check($sformatf("R2 full vec %0d", v), 32'(full_o), 32'h1);
            check($sformatf("R4 ad vec %0d", v), 32'(ad_o), 32'(eadx));
            check($sformatf("R3 perr vec %0d", v), 32'(perr_o), 32'(ep));
            check($sformatf("R6 ferr vec %0d", v), 32'(ferr_o), 32'(ef));
            check($sformatf("R7 no overrun vec %0d", v), 32'(oerr_o), 32'h0);
            check($sformatf("R10 irq vec %0d", v), 32'(irq_o), 32'h1);
            pulse_rd();
            check($sformatf("R9 read clears full vec %0d", v), 32'(full_o), 32'h0);
            check($sformatf("R9 read keeps data vec %0d", v), 32'(rx_data_o), 32'(d));
            pulse_clr();
            check($sformatf("R9 clear errors vec %0d", v),
                  {29'd0, perr_o, oerr_o, ferr_o}, 32'h0);
            check($sformatf("R10 irq idle vec %0d", v), 32'(irq_o), 32'h0);
        end

        // R7: overrun in plain asynchronous mode
        set_mode(2'd0, 1'b0, 1'b0);
        send_async(8'h11, 1'b0, 1'b0, 1'b1);
        send_async(8'h22, 1'b0, 1'b0, 1'b1);
        check("R7 async overrun flag", 32'(oerr_o), 32'h1);
        check("R7 async overrun keeps data", 32'(rx_data_o), 32'h11);
        check("R7 async overrun keeps full", 32'(full_o), 32'h1);
        pulse_clr();
        check("R9 clear keeps full", 32'(full_o), 32'h1);
        check("R9 clear drops overrun", 32'(oerr_o), 32'h0);
        pulse_rd();

        // R7: overrun in synchronous mode
        set_mode(2'd2, 1'b0, 1'b0);
        send_sync(8'h33);
        send_sync(8'h44);
        check("R7 sync overrun flag", 32'(oerr_o), 32'h1);
        check("R7 sync overrun keeps data", 32'(rx_data_o), 32'h33);
        pulse_rd();
        pulse_clr();

        // R8: short start glitch then a good frame
        set_mode(2'd0, 1'b0, 1'b0);
        rxd_i = 1'b0;
        repeat (2) @(negedge clk);
        rxd_i = 1'b1;
        repeat (3 * OVS) @(negedge clk);
        check("R8 false start no full", 32'(full_o), 32'h0);
        check("R8 false start no flags",
              {29'd0, perr_o, oerr_o, ferr_o}, 32'h0);
        send_async(8'h5A, 1'b0, 1'b0, 1'b1);
        check("R8 recovery data", 32'(rx_data_o), 32'h5A);
        check("R8 recovery full", 32'(full_o), 32'h1);
        pulse_rd();

        // R10: enable gating
        rie_i = 1'b0;
        send_async(8'hC3, 1'b0, 1'b0, 1'b1);
        check("R10 full with enable low", 32'(full_o), 32'h1);
        check("R10 irq masked", 32'(irq_o), 32'h0);
        rie_i = 1'b1;
        @(negedge clk);
        check("R10 irq unmasked", 32'(irq_o), 32'h1);
        pulse_rd();

        finish_run();
    end
endmodule